// File: doc/BRIEF.md
# Store Queue with Load Ordering Check

This block keeps the stores that are in flight in program order and decides, for a load that has its address, whether it may proceed. Each store is allocated with a sequence number. Its address and its data arrive later, each on its own update port and named by that sequence number. A load presents its address and its own sequence number. The block scans every store that is older than the load. It returns one of three results in the same cycle: the load must wait, the load takes its data from a queued store, or the load may read memory.

The policy is conservative. Any older store whose address is still unknown holds the load, so no load is ever issued on a guess and nothing needs replaying. When several older stores match the address, the youngest of them supplies the data. A match whose data has not arrived also holds the load. Stores leave from the head only, in order, when commit is raised. The write to memory is presented on the memory port in that same cycle.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty, `alloc_ready` is 1, and a load is sent to memory (`load_to_mem`=1).
- R2: The queue accepts allocations until it holds DEPTH stores. `alloc_ready` is then 0 and a further allocation is ignored, even when a commit falls in the same cycle.
- R3: A load is held (`load_stall`=1) while any store older than it has no known address.
- R4: When one or more older stores have an address equal to the load address, the data of the youngest of them is given on `load_fwd_data` with `load_fwd`=1.
- R5: If the youngest older matching store has no data yet, the load is held rather than forwarded.
- R6: Stores whose sequence number is equal to or younger than the load's play no part in the check.
- R7: With every older address known and none matching, `load_to_mem`=1.
- R8: On `commit_valid` with the head store complete, `mem_wr_en`=1 carries that store's address and data in the same cycle, and the store is gone from the next cycle on. A load in that same cycle still sees it.
- R9: A commit while the head store lacks address or data writes nothing and removes nothing.
- R10: Age is judged by the signed difference of sequence numbers modulo 2^SEQ_W, so the order is kept across wrap-around.
- R11: When `load_valid` is 1, exactly one of `load_stall`, `load_fwd` and `load_to_mem` is 1. When it is 0, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_ready | output | 1 | Queue has a free slot |
| addr_upd_valid | input | 1 | Store address is being supplied |
| addr_upd_seq | input | SEQ_W | Which store gets the address |
| addr_upd_addr | input | ADDR_W | Store address |
| data_upd_valid | input | 1 | Store data is being supplied |
| data_upd_seq | input | SEQ_W | Which store gets the data |
| data_upd_data | input | DATA_W | Store data |
| load_valid | input | 1 | A load asks for a decision |
| load_seq | input | SEQ_W | Load sequence number |
| load_addr | input | ADDR_W | Load address |
| load_stall | output | 1 | Load must wait |
| load_fwd | output | 1 | Load takes data from the queue |
| load_fwd_data | output | DATA_W | Forwarded data |
| load_to_mem | output | 1 | Load may read memory |
| commit_valid | input | 1 | Retire the head store |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |

## Verification
A commit and a load check can fall in the same cycle. The bench raises `commit_valid` on the oldest store while a load to that store's address is presented. It expects the memory write and the forward of that same data together. On the next cycle the same load must go to memory. The bench also raises a commit while the queue is full and offers an allocation in that cycle. It judges that the allocation was dropped by what later loads report.

// File: rtl/store_queue.sv
module store_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic              alloc_ready,
  input  logic              addr_upd_valid,
  input  logic [SEQ_W-1:0]  addr_upd_seq,
  input  logic [ADDR_W-1:0] addr_upd_addr,
  input  logic              data_upd_valid,
  input  logic [SEQ_W-1:0]  data_upd_seq,
  input  logic [DATA_W-1:0] data_upd_data,
  input  logic              load_valid,
  input  logic [SEQ_W-1:0]  load_seq,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              load_stall,
  output logic              load_fwd,
  output logic [DATA_W-1:0] load_fwd_data,
  output logic              load_to_mem,
  input  logic              commit_valid,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  ent_v, ent_ak, ent_dk;
  logic [SEQ_W-1:0]  ent_seq  [DEPTH];
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;

  logic alloc_fire, retire;
  logic unk, hit, hit_dk;
  logic [DATA_W-1:0] hit_data;

  function automatic logic is_older(input logic [SEQ_W-1:0] st, input logic [SEQ_W-1:0] ld);
    logic signed [SEQ_W-1:0] d;
    d = ld - st;
    return d > 0;
  endfunction

  assign alloc_ready = (count != CNT_W'(DEPTH));
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign retire      = commit_valid && ent_v[head] && ent_ak[head] && ent_dk[head];

  assign mem_wr_en   = retire;
  assign mem_wr_addr = ent_addr[head];
  assign mem_wr_data = ent_data[head];

  always_comb begin
    logic [IDX_W-1:0] pos;
    unk = 1'b0;
    hit = 1'b0;
    hit_dk = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      pos = head + IDX_W'(i);
      if (ent_v[pos] && is_older(ent_seq[pos], load_seq)) begin
        if (!ent_ak[pos]) begin
          unk = 1'b1;
        end else if (ent_addr[pos] == load_addr) begin
          hit = 1'b1;
          hit_dk = ent_dk[pos];
          hit_data = ent_data[pos];
        end
      end
    end
  end

  assign load_stall    = load_valid && (unk || (hit && !hit_dk));
  assign load_fwd      = load_valid && !unk && hit && hit_dk;
  assign load_to_mem   = load_valid && !unk && !hit;
  assign load_fwd_data = load_fwd ? hit_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v  <= '0;
      ent_ak <= '0;
      ent_dk <= '0;
      head   <= '0;
      tail   <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_seq[i]  <= '0;
        ent_addr[i] <= '0;
        ent_data[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_v[i] && addr_upd_valid && ent_seq[i] == addr_upd_seq) begin
          ent_ak[i]   <= 1'b1;
          ent_addr[i] <= addr_upd_addr;
        end
        if (ent_v[i] && data_upd_valid && ent_seq[i] == data_upd_seq) begin
          ent_dk[i]   <= 1'b1;
          ent_data[i] <= data_upd_data;
        end
      end
      if (retire) begin
        ent_v[head]  <= 1'b0;
        ent_ak[head] <= 1'b0;
        ent_dk[head] <= 1'b0;
        head <= head + 1'b1;
      end
      if (alloc_fire) begin
        ent_v[tail]   <= 1'b1;
        ent_ak[tail]  <= 1'b0;
        ent_dk[tail]  <= 1'b0;
        ent_seq[tail] <= alloc_seq;
        tail <= tail + 1'b1;
      end
      count <= count + CNT_W'(alloc_fire) - CNT_W'(retire);
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !alloc_fire) |=> (count == $past(count) - 1'b1));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !mem_wr_en && !alloc_fire) |=> $stable(count));

  p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $countones({load_stall, load_fwd, load_to_mem}) == 1);

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |-> !(load_stall || load_fwd || load_to_mem));
endmodule

// File: tb/test_store_queue.sv
module test_store_queue;
  localparam int DEPTH = 4, ADDR_W = 16, DATA_W = 32, SEQ_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, addr_upd_valid = 0, data_upd_valid = 0, load_valid = 0, commit_valid = 0;
  logic [SEQ_W-1:0] alloc_seq = '0, addr_upd_seq = '0, data_upd_seq = '0, load_seq = '0;
  logic [ADDR_W-1:0] addr_upd_addr = '0, load_addr = '0;
  logic [DATA_W-1:0] data_upd_data = '0;
  logic alloc_ready, load_stall, load_fwd, load_to_mem, mem_wr_en;
  logic [DATA_W-1:0] load_fwd_data, mem_wr_data;
  logic [ADDR_W-1:0] mem_wr_addr;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) i_store_queue (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_ready(alloc_ready),
    .addr_upd_valid(addr_upd_valid), .addr_upd_seq(addr_upd_seq), .addr_upd_addr(addr_upd_addr),
    .data_upd_valid(data_upd_valid), .data_upd_seq(data_upd_seq), .data_upd_data(data_upd_data),
    .load_valid(load_valid), .load_seq(load_seq), .load_addr(load_addr),
    .load_stall(load_stall), .load_fwd(load_fwd), .load_fwd_data(load_fwd_data),
    .load_to_mem(load_to_mem), .commit_valid(commit_valid),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data));

  // result code: 0 memory, 1 forward, 2 stall
  localparam logic [57:0] VEC [7] = '{
    {8'd11, 16'h0100, 2'd1, 32'h0000AAAA},
    {8'd13, 16'h0100, 2'd1, 32'h0000CCCC},
    {8'd13, 16'h0200, 2'd1, 32'h0000BBBB},
    {8'd13, 16'h0300, 2'd0, 32'h00000000},
    {8'd14, 16'h0300, 2'd2, 32'h00000000},
    {8'd10, 16'h0100, 2'd0, 32'h00000000},
    {8'd12, 16'h0100, 2'd1, 32'h0000AAAA}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    alloc_valid = 0; addr_upd_valid = 0; data_upd_valid = 0; load_valid = 0; commit_valid = 0;
  endtask

  task automatic alloc(input logic [7:0] s);
    @(negedge clk); alloc_valid = 1; alloc_seq = s;
    @(posedge clk); idle();
  endtask

  task automatic set_addr(input logic [7:0] s, input logic [15:0] a);
    @(negedge clk); addr_upd_valid = 1; addr_upd_seq = s; addr_upd_addr = a;
    @(posedge clk); idle();
  endtask

  task automatic set_data(input logic [7:0] s, input logic [31:0] d);
    @(negedge clk); data_upd_valid = 1; data_upd_seq = s; data_upd_data = d;
    @(posedge clk); idle();
  endtask

  // code 0 memory, 1 forward, 2 stall
  task automatic probe(input string req, input logic [7:0] s, input logic [15:0] a,
                       input logic [1:0] code, input logic [31:0] d);
    @(negedge clk); load_valid = 1; load_seq = s; load_addr = a;
    #1;
    check(req, {61'd0, load_stall, load_fwd, load_to_mem},
          {61'd0, code == 2'd2, code == 2'd1, code == 2'd0});
    if (code == 2'd1) check(req, {32'd0, load_fwd_data}, {32'd0, d});
    load_valid = 0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R1 ready", {63'd0, alloc_ready}, 64'd1);
    probe("R1 empty load", 8'd5, 16'h0100, 2'd0, 0);
    @(negedge clk); #1;
    check("R11 idle", {61'd0, load_stall, load_fwd, load_to_mem}, 64'd0);

    alloc(8'd10); alloc(8'd11); alloc(8'd12); alloc(8'd13);
    set_addr(8'd10, 16'h0100); set_data(8'd10, 32'hAAAA);
    set_addr(8'd11, 16'h0200); set_data(8'd11, 32'hBBBB);
    set_addr(8'd12, 16'h0100); set_data(8'd12, 32'hCCCC);
    #1 check("R2 full", {63'd0, alloc_ready}, 64'd0);

    // R4 R6 R7 R3 via the vector table
    foreach (VEC[i]) begin
      probe($sformatf("R3/R4/R6/R7 vec%0d", i), VEC[i][57:50], VEC[i][49:34], VEC[i][33:32], VEC[i][31:0]);
    end

    // R5: address matches, data missing
    set_addr(8'd13, 16'h0100);
    probe("R5 no data", 8'd14, 16'h0100, 2'd2, 0);
    probe("R4 other addr", 8'd14, 16'h0200, 2'd1, 32'hBBBB);
    set_data(8'd13, 32'hDDDD);
    probe("R4 youngest", 8'd14, 16'h0100, 2'd1, 32'hDDDD);

    // R2: allocation while full is dropped, even with a commit in the same cycle
    @(negedge clk); alloc_valid = 1; alloc_seq = 8'd14; commit_valid = 1;
    load_valid = 1; load_seq = 8'd11; load_addr = 16'h0100;
    #1;
    check("R8 wr en", {63'd0, mem_wr_en}, 64'd1);
    check("R8 wr addr", {48'd0, mem_wr_addr}, 64'h0100);
    check("R8 wr data", {32'd0, mem_wr_data}, 64'hAAAA);
    check("R8 same-cycle fwd", {32'd0, load_fwd_data}, 64'hAAAA);
    @(posedge clk); idle();
    probe("R8 gone", 8'd11, 16'h0100, 2'd0, 0);
    probe("R2 dropped", 8'd20, 16'h0300, 2'd0, 0);
    #1 check("R8 slot free", {63'd0, alloc_ready}, 64'd1);

    // R9: incomplete head is not retired
    alloc(8'd14);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); commit_valid = 1; #1;
      check("R8 drain", {63'd0, mem_wr_en}, 64'd1);
      @(posedge clk); idle();
    end
    @(negedge clk); commit_valid = 1; #1;
    check("R9 no write", {63'd0, mem_wr_en}, 64'd0);
    @(posedge clk); idle();
    probe("R9 still held", 8'd15, 16'h0300, 2'd2, 0);

    // R10: wrap of sequence numbers
    @(negedge clk); rst_n = 0;
    @(posedge clk); @(negedge clk); rst_n = 1;
    alloc(8'd254); alloc(8'd255); alloc(8'd0);
    set_addr(8'd254, 16'h0040); set_data(8'd254, 32'd1);
    set_addr(8'd255, 16'h0040); set_data(8'd255, 32'd2);
    probe("R10 unknown across wrap", 8'd1, 16'h0040, 2'd2, 0);
    set_addr(8'd0, 16'h0050); set_data(8'd0, 32'd3);
    probe("R10 youngest across wrap", 8'd1, 16'h0040, 2'd1, 32'd2);
    probe("R10 seq0 load", 8'd0, 16'h0040, 2'd1, 32'd2);
    probe("R10 seq255 load", 8'd255, 16'h0040, 2'd1, 32'd1);
    probe("R10 seq254 load", 8'd254, 16'h0040, 2'd0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule